// File: doc/BRIEF.md
# Multi-Width 128-bit Integer ALU

This block is the integer execution unit of a machine whose general registers are 128 bits wide. Each issued operation takes two register operands, or one register and a 12-bit immediate. It produces a registered 128-bit result and a valid flag one clock later. The operation set covers:

- add and subtract,
- the three bitwise logic functions,
- signed and unsigned set-less-than,
- shift left logical, shift right logical and shift right arithmetic.

A width select picks one of three operand widths. Full width (128 bits) supports every operation. The two narrow widths are doubleword (64 bits) and word (32 bits), and they support only add, subtract and the three shifts. A narrow operation works on the low bits of its operands, and its result is sign-extended from the top bit of the narrow field up to bit 127. An upstream decoder derives the width select from the major opcode. The ALU simply trusts the code it receives, except that it rejects the reserved width code and any operation the selected width does not support.

Top module: `mx128_alu`

## Requirements
- R1: At full width (width code 2'b00), ADD (op 0) returns the sum of the two operands modulo 2^128, and SUB (op 1) returns the difference `rs1 - operand B` modulo 2^128.
- R2: When `use_imm` is 1, operand B is the 12-bit immediate sign-extended to 128 bits; when it is 0, operand B is `rs2`.
- R3: At word width (width code 2'b10), ADD, SUB and the shifts compute on bits 31:0 of the operands only, and result bits 127:32 all equal result bit 31.
- R4: At doubleword width (width code 2'b01), ADD, SUB and the shifts compute on bits 63:0 of the operands only, and result bits 127:64 all equal result bit 63.
- R5: The shift amount is taken from the low bits of operand B: 7 bits at full width, 6 bits at doubleword width and 5 bits at word width. The higher bits of operand B are ignored. The ops are SLL = op 7, SRL = op 8, SRA = op 9, and the value shifted is `rs1`.
- R6: At narrow width, SRA fills vacated bits from bit 31 (word) or bit 63 (doubleword) of `rs1`, and SRL fills them with zeros before the sign extension. At full width, SRA fills from bit 127.
- R7: At full width, AND (op 2), OR (op 3) and XOR (op 4) return the bitwise function of `rs1` and operand B.
- R8: At full width, SLT (op 5, signed) and SLTU (op 6, unsigned) return 1 in bit 0 when `rs1` is less than operand B and 0 otherwise; bits 127:1 are always 0.
- R9: An issued operation is rejected when its op code is 10 to 15, when its width code is 2'b11, or when a logic op or compare is paired with a narrow width. A rejected operation gives `result_valid` = 0 and `result` = 0 in the following cycle.
- R10: Results appear exactly one clock after `issue` is sampled high. When `issue` was low, the next cycle shows `result_valid` = 0 and `result` = 0. Reset clears both `result_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 SLT, 6 SLTU, 7 SLL, 8 SRL, 9 SRA) |
| width | input | 2 | Operand width (00 full, 01 doubleword, 10 word, 11 reserved) |
| use_imm | input | 1 | Selects the sign-extended immediate as operand B |
| rs1 | input | 128 | First source operand |
| rs2 | input | 128 | Second source operand |
| imm | input | 12 | Immediate field |
| result | output | 128 | Registered result |
| result_valid | output | 1 | Registered flag marking a legal issued operation |

## Verification
Directed vectors place carries and borrows right at the narrow boundaries. For example, 0x7FFFFFFF + 1 at word width and the 64-bit equivalent at doubleword width must flip the sign of the whole register, which separates correct sign extension from zero extension or a full-width computation. Shift vectors put set bits above the 5-, 6- and 7-bit amount fields and load sign bits at positions 31, 63 and 127. These cases expose wrong masking and a wrong fill source. Compare vectors pair negative values with positive ones, so the signed and unsigned forms give opposite answers. Illegal width/operation pairs, back-to-back issues and idle cycles separate the valid qualification from the datapath, and a long run of pseudo-random mixed vectors covers the remaining combinations.

// File: rtl/mx128_pkg.sv
`timescale 1ns/1ps
package mx128_pkg;

    // Operand width codes; the decoder upstream maps major opcodes onto these.
    localparam logic [1:0] WD_FULL = 2'b00;
    localparam logic [1:0] WD_DBL  = 2'b01;
    localparam logic [1:0] WD_WORD = 2'b10;
    localparam logic [1:0] WD_RSVD = 2'b11;

    // Operation codes.
    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_SUB  = 4'd1;
    localparam logic [3:0] OP_AND  = 4'd2;
    localparam logic [3:0] OP_OR   = 4'd3;
    localparam logic [3:0] OP_XOR  = 4'd4;
    localparam logic [3:0] OP_SLT  = 4'd5;
    localparam logic [3:0] OP_SLTU = 4'd6;
    localparam logic [3:0] OP_SLL  = 4'd7;
    localparam logic [3:0] OP_SRL  = 4'd8;
    localparam logic [3:0] OP_SRA  = 4'd9;
    localparam logic [3:0] OP_LAST = OP_SRA;

    // Which functional path drives the result.
    typedef enum logic [1:0] {
        PATH_ARITH = 2'd0,
        PATH_SHIFT = 2'd1,
        PATH_NONE  = 2'd2
    } path_e;

endpackage

// File: rtl/mx128_opnd.sv
`timescale 1ns/1ps
// Operand B selection and width-dependent shift-amount masking.
module mx128_opnd
    import mx128_pkg::*;
#(
    parameter int XLEN = 128,
    parameter int IMMW = 12,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [1:0]      width,
    input  logic            use_imm,
    input  logic [XLEN-1:0] rs2,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] opb,
    output logic [SHW-1:0]  shamt
);

    localparam int SH_DBL  = SHW - 1;
    localparam int SH_WORD = SHW - 2;

    logic [XLEN-1:0] imm_ext;
    logic [SHW-1:0]  amt_mask;

    assign imm_ext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign opb     = use_imm ? imm_ext : rs2;

    always_comb begin
        case (width)
            WD_DBL:  amt_mask = SHW'((1 << SH_DBL) - 1);
            WD_WORD: amt_mask = SHW'((1 << SH_WORD) - 1);
            default: amt_mask = '1;
        endcase
    end

    assign shamt = opb[SHW-1:0] & amt_mask;

endmodule

// File: rtl/mx128_arith.sv
`timescale 1ns/1ps
// Adder, subtractor, bitwise logic and comparisons on the full datapath.
module mx128_arith
    import mx128_pkg::*;
#(
    parameter int XLEN = 128
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] sum;
    logic [XLEN:0]   diff;
    logic            no_borrow;
    logic            lt_u;
    logic            lt_s;

    assign sum       = a + b;
    assign diff      = {1'b0, a} + {1'b0, ~b} + {{XLEN{1'b0}}, 1'b1};
    assign no_borrow = diff[XLEN];
    assign lt_u      = ~no_borrow;
    // Differing signs decide directly; equal signs cannot overflow the difference.
    assign lt_s      = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

    always_comb begin
        case (op)
            OP_ADD:  res = sum;
            OP_SUB:  res = diff[XLEN-1:0];
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_u};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mx128_shift.sv
`timescale 1ns/1ps
// Barrel shifter; narrow right shifts first re-extend the truncated source.
module mx128_shift
    import mx128_pkg::*;
#(
    parameter int XLEN = 128,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [3:0]      op,
    input  logic [1:0]      width,
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);

    localparam int DW = XLEN / 2;
    localparam int WW = XLEN / 4;

    logic [XLEN-1:0] src;
    logic            fill;

    always_comb begin
        fill = 1'b0;
        case (width)
            WD_DBL: begin
                if (op == OP_SRA) fill = a[DW-1];
                src = {{(XLEN-DW){fill}}, a[DW-1:0]};
            end
            WD_WORD: begin
                if (op == OP_SRA) fill = a[WW-1];
                src = {{(XLEN-WW){fill}}, a[WW-1:0]};
            end
            default: src = a;
        endcase
    end

    always_comb begin
        case (op)
            OP_SLL:  res = src << shamt;
            OP_SRL:  res = src >> shamt;
            OP_SRA:  res = $signed(src) >>> shamt;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mx128_narrow.sv
`timescale 1ns/1ps
// Sign-extends the low field of a result according to the operand width.
module mx128_narrow
    import mx128_pkg::*;
#(
    parameter int XLEN = 128
) (
    input  logic [1:0]      width,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] out
);

    localparam int DW = XLEN / 2;
    localparam int WW = XLEN / 4;

    always_comb begin
        case (width)
            WD_DBL:  out = {{(XLEN-DW){val[DW-1]}}, val[DW-1:0]};
            WD_WORD: out = {{(XLEN-WW){val[WW-1]}}, val[WW-1:0]};
            default: out = val;
        endcase
    end

endmodule

// File: rtl/mx128_alu.sv
`timescale 1ns/1ps
module mx128_alu
    import mx128_pkg::*;
#(
    parameter int XLEN = 128,
    parameter int IMMW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [3:0]      op,
    input  logic [1:0]      width,
    input  logic            use_imm,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] result,
    output logic            result_valid
);

    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
    } out_state_t;

    out_state_t state_d, state_q;

    logic [XLEN-1:0] opb;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] arith_res;
    logic [XLEN-1:0] shift_res;
    logic [XLEN-1:0] pre_res;
    logic [XLEN-1:0] ext_res;
    path_e           path;
    logic            legal;

    mx128_opnd #(.XLEN(XLEN), .IMMW(IMMW), .SHW(SHW)) u_opnd (
        .width   (width),
        .use_imm (use_imm),
        .rs2     (rs2),
        .imm     (imm),
        .opb     (opb),
        .shamt   (shamt)
    );

    mx128_arith #(.XLEN(XLEN)) u_arith (
        .op  (op),
        .a   (rs1),
        .b   (opb),
        .res (arith_res)
    );

    mx128_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .op    (op),
        .width (width),
        .a     (rs1),
        .shamt (shamt),
        .res   (shift_res)
    );

    mx128_narrow #(.XLEN(XLEN)) u_narrow (
        .width (width),
        .val   (pre_res),
        .out   (ext_res)
    );

    // Legality: narrow widths admit only add, subtract and shifts.
    always_comb begin
        if (op > OP_LAST || width == WD_RSVD) begin
            path = PATH_NONE;
        end else if (op inside {OP_SLL, OP_SRL, OP_SRA}) begin
            path = PATH_SHIFT;
        end else if (width == WD_FULL || op == OP_ADD || op == OP_SUB) begin
            path = PATH_ARITH;
        end else begin
            path = PATH_NONE;
        end
        legal = (path != PATH_NONE);
    end

    assign pre_res = (path == PATH_SHIFT) ? shift_res : arith_res;

    always_comb begin
        state_d.valid = issue && legal;
        state_d.res   = (issue && legal) ? ext_res : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result       = state_q.res;
    assign result_valid = state_q.valid;

endmodule

// File: rtl/mx128_alu_chk.sv
`timescale 1ns/1ps
module mx128_alu_chk #(
    parameter int XLEN = 128,
    parameter int IMMW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic [3:0]      op,
    input logic [1:0]      width,
    input logic            use_imm,
    input logic [XLEN-1:0] rs1,
    input logic [XLEN-1:0] rs2,
    input logic [IMMW-1:0] imm,
    input logic [XLEN-1:0] result,
    input logic            result_valid
);

    localparam int DW = XLEN / 2;
    localparam int WW = XLEN / 4;

    logic [XLEN-1:0] chk_b;
    logic [XLEN-1:0] chk_sum;
    assign chk_b   = use_imm ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : rs2;
    assign chk_sum = rs1 + chk_b;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!result_valid && result == '0)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!result_valid && result == '0)); // R10

    AST_FULL_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd0 && width == 2'b00) |=> (result_valid && result == $past(chk_sum))); // R1

    AST_WORD_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && width == 2'b10) |=> (result[XLEN-1:WW-1] == '0 || result[XLEN-1:WW-1] == '1)); // R3

    AST_DBL_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && width == 2'b01) |=> (result[XLEN-1:DW-1] == '0 || result[XLEN-1:DW-1] == '1)); // R4

    AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == 4'd5 || op == 4'd6)) |=> (result[XLEN-1:1] == '0)); // R8

    AST_RSVD_WIDTH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && width == 2'b11) |=> (!result_valid && result == '0)); // R9

    AST_HIGH_OP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op > 4'd9) |=> (!result_valid && result == '0)); // R9

endmodule

bind mx128_alu mx128_alu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .op           (op),
    .width        (width),
    .use_imm      (use_imm),
    .rs1          (rs1),
    .rs2          (rs2),
    .imm          (imm),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/sim_mx128_alu.sv
`timescale 1ns/1ps
module sim_mx128_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [3:0]   op = '0;
    logic [1:0]   width = '0;
    logic         use_imm = 1'b0;
    logic [127:0] rs1 = '0;
    logic [127:0] rs2 = '0;
    logic [11:0]  imm = '0;
    logic [127:0] result;
    logic         result_valid;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic         v;
        logic [127:0] r;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    mx128_alu u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .op           (op),
        .width        (width),
        .use_imm      (use_imm),
        .rs1          (rs1),
        .rs2          (rs2),
        .imm          (imm),
        .result       (result),
        .result_valid (result_valid)
    );

    // Reference model written from the requirements with native-width variables.
    function automatic logic [128:0] model(input logic iss, input logic [3:0] o,
                                           input logic [1:0] w, input logic ui,
                                           input logic [127:0] a, input logic [127:0] r2,
                                           input logic [11:0] im);
        logic [127:0] b;
        logic [127:0] r;
        logic [63:0]  x64;
        logic [63:0]  y64;
        logic [63:0]  z64;
        logic [31:0]  x32;
        logic [31:0]  y32;
        logic [31:0]  z32;
        logic         ok;
        b   = ui ? {{116{im[11]}}, im} : r2;
        r   = '0;
        ok  = 1'b1;
        x64 = a[63:0];
        y64 = b[63:0];
        x32 = a[31:0];
        y32 = b[31:0];
        z64 = '0;
        z32 = '0;
        if (!iss) return {1'b0, 128'd0};
        case (w)
            2'b00: case (o)
                4'd0: r = a + b;
                4'd1: r = a - b;
                4'd2: r = a & b;
                4'd3: r = a | b;
                4'd4: r = a ^ b;
                4'd5: r = ($signed(a) < $signed(b)) ? 128'd1 : 128'd0;
                4'd6: r = (a < b) ? 128'd1 : 128'd0;
                4'd7: r = a << b[6:0];
                4'd8: r = a >> b[6:0];
                4'd9: r = $signed(a) >>> b[6:0];
                default: ok = 1'b0;
            endcase
            2'b01: begin
                case (o)
                    4'd0: z64 = x64 + y64;
                    4'd1: z64 = x64 - y64;
                    4'd7: z64 = x64 << y64[5:0];
                    4'd8: z64 = x64 >> y64[5:0];
                    4'd9: z64 = $signed(x64) >>> y64[5:0];
                    default: ok = 1'b0;
                endcase
                r = {{64{z64[63]}}, z64};
            end
            2'b10: begin
                case (o)
                    4'd0: z32 = x32 + y32;
                    4'd1: z32 = x32 - y32;
                    4'd7: z32 = x32 << y32[4:0];
                    4'd8: z32 = x32 >> y32[4:0];
                    4'd9: z32 = $signed(x32) >>> y32[4:0];
                    default: ok = 1'b0;
                endcase
                r = {{96{z32[31]}}, z32};
            end
            default: ok = 1'b0;
        endcase
        if (!ok) return {1'b0, 128'd0};
        return {1'b1, r};
    endfunction

    task automatic drive(input logic iss, input logic [3:0] o, input logic [1:0] w,
                         input logic ui, input logic [127:0] a, input logic [127:0] b,
                         input logic [11:0] im, input string tag);
        logic [128:0] m;
        exp_t e;
        @(negedge clk);
        issue   = iss;
        op      = o;
        width   = w;
        use_imm = ui;
        rs1     = a;
        rs2     = b;
        imm     = im;
        m       = model(iss, o, w, ui, a, b, im);
        e.v     = m[128];
        e.r     = m[127:0];
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: one expected item per cycle, sampled 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (result_valid !== e.v || result !== e.r) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b r=%h expected v=%0b r=%h",
                             e.tag, result_valid, result, e.v, e.r);
                end
            end
        end
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        report();
        $finish;
    end

    localparam logic [127:0] ONES = '1;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        n_cmp++;
        if (result_valid !== 1'b0 || result !== '0) begin
            n_bad++;
            $display("FAIL R10 reset: got v=%0b r=%h expected v=0 r=0", result_valid, result);
        end

        // R1 full-width wrap
        drive(1, 4'd0, 2'b00, 0, ONES, 128'd1, 12'd0, "R1 add wrap");
        drive(1, 4'd1, 2'b00, 0, 128'd0, 128'd1, 12'd0, "R1 sub borrow");
        // R2 immediate sign extension
        drive(1, 4'd0, 2'b00, 1, 128'd5, ONES, 12'h800, "R2 add neg imm");
        drive(1, 4'd5, 2'b00, 1, 128'd0, 128'd0, 12'hfff, "R2 slt imm -1");
        drive(1, 4'd6, 2'b00, 1, 128'd7, 128'd0, 12'hfff, "R2 sltu imm max");
        // R3 word width
        drive(1, 4'd0, 2'b10, 0, {96'hABCD, 32'h7fffffff}, {96'h1234, 32'h1}, 12'd0, "R3 word add overflow");
        drive(1, 4'd1, 2'b10, 0, {96'hFFFF, 32'h5}, {96'h0, 32'h3}, 12'd0, "R3 word sub high garbage");
        // R4 doubleword width
        drive(1, 4'd0, 2'b01, 0, {64'h1, 64'h7fffffffffffffff}, 128'd1, 12'd0, "R4 dword add overflow");
        drive(1, 4'd1, 2'b01, 1, {64'hdead, 64'h0}, 128'd0, 12'h001, "R4 dword sub imm");
        // R5 shift amount masking
        drive(1, 4'd7, 2'b00, 1, 128'd1, 128'd0, 12'hfff, "R5 full sll 127");
        drive(1, 4'd8, 2'b00, 0, ONES, {120'hff, 8'h80}, 12'd0, "R5 full srl amount 0");
        drive(1, 4'd7, 2'b10, 0, 128'h40000001, 128'd33, 12'd0, "R5 word sll masked");
        drive(1, 4'd8, 2'b01, 0, {64'hffff, 64'h8000000000000000}, 128'd65, 12'd0, "R5 dword srl masked");
        drive(1, 4'd8, 2'b00, 1, ONES, 128'd0, 12'h040, "R5 full srl 64 imm");
        // R6 narrow arithmetic fill
        drive(1, 4'd9, 2'b10, 0, {96'h0, 32'h80000000}, 128'd4, 12'd0, "R6 word sra");
        drive(1, 4'd9, 2'b10, 0, {96'hFFFF_FFFF, 32'h70000000}, 128'd4, 12'd0, "R6 word sra pos");
        drive(1, 4'd9, 2'b01, 0, {64'h0, 64'h8000000000000000}, 128'd8, 12'd0, "R6 dword sra");
        drive(1, 4'd9, 2'b00, 0, {1'b1, 127'd0}, 128'd100, 12'd0, "R6 full sra");
        drive(1, 4'd8, 2'b10, 0, {96'hFFFF, 32'h80000000}, 128'd1, 12'd0, "R6 word srl");
        // R7 logic
        drive(1, 4'd2, 2'b00, 0, {64'hF0F0, 64'hFF00}, {64'hFF00, 64'h0FF0}, 12'd0, "R7 and");
        drive(1, 4'd3, 2'b00, 0, 128'hA, 128'h5, 12'd0, "R7 or");
        drive(1, 4'd4, 2'b00, 1, ONES, 128'd0, 12'h0f0, "R7 xor imm");
        // R8 comparisons
        drive(1, 4'd5, 2'b00, 0, ONES, 128'd1, 12'd0, "R8 slt neg<pos");
        drive(1, 4'd6, 2'b00, 0, ONES, 128'd1, 12'd0, "R8 sltu max>1");
        drive(1, 4'd5, 2'b00, 0, 128'd3, 128'd3, 12'd0, "R8 slt equal");
        // R9 rejected combos
        drive(1, 4'd2, 2'b10, 0, ONES, ONES, 12'd0, "R9 and at word");
        drive(1, 4'd5, 2'b01, 0, 128'd0, 128'd1, 12'd0, "R9 slt at dword");
        drive(1, 4'd0, 2'b11, 0, 128'd1, 128'd1, 12'd0, "R9 reserved width");
        drive(1, 4'd12, 2'b00, 0, 128'd1, 128'd1, 12'd0, "R9 op 12");
        // R10 idle and back-to-back
        drive(0, 4'd0, 2'b00, 0, ONES, ONES, 12'd0, "R10 idle");
        drive(1, 4'd0, 2'b00, 0, 128'd2, 128'd3, 12'd0, "R10 back to back a");
        drive(1, 4'd1, 2'b00, 0, 128'd2, 128'd3, 12'd0, "R10 back to back b");
        drive(0, 4'd1, 2'b01, 1, 128'd9, 128'd9, 12'd9, "R10 idle after");

        for (int i = 0; i < 400; i++) begin
            logic [127:0] a;
            logic [127:0] b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (i % 7 == 0) a = {~a[127:64], 64'h7fffffffffffffff};
            if (i % 5 == 0) b = {b[127:32], 32'h1};
            drive(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 11)),
                  2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  a, b, 12'($urandom), "random mix");
        end
        drive(0, 4'd0, 2'b00, 0, 128'd0, 128'd0, 12'd0, "R10 final idle");

        repeat (3) @(posedge clk);
        #5;
        report();
        $finish;
    end

endmodule